// File: doc/BRIEF.md
# Upward-Growing Stack Pointer Unit

This block keeps the 8-bit stack pointer of a small 8-bit microcontroller core. It turns push and pop strobes into write and read cycles on a 256-byte internal data RAM that sits outside the block. The stack grows toward higher addresses. A push first moves the pointer up by one and then stores the byte at the new address. A pop reads the byte at the current address and then moves the pointer down by one.

The reset value of the pointer is 0x07, so the first push after reset lands at 0x08, just above the lowest register bank. Software can load the pointer with any byte through a dedicated load port, which moves the stack away from memory that is in use. The RAM has one cycle of read latency, so a popped byte appears, with a valid flag, in the cycle after the pop strobe. Pointer arithmetic wraps modulo 256 and raises no flag.

Top module: `upstack_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer becomes 0x07 and `pop_valid_o` becomes 0. Both values are visible after that edge.
- R2: In a cycle with a granted push, `ram_we_o` is 1, `ram_addr_o` equals `sp_o + 1` and `ram_wdata_o` equals `push_data_i`. After the edge, `sp_o` holds that address.
- R3: The first push after reset writes to address 0x08 and leaves `sp_o` at 0x08.
- R4: In a cycle with a granted pop, `ram_we_o` is 0 and `ram_addr_o` equals `sp_o`. After the edge, `sp_o` is one lower.
- R5: `pop_valid_o` is 1 exactly in the cycle after a granted pop. In that cycle `pop_data_o` carries the RAM byte read at the popped address. In every other cycle `pop_valid_o` is 0 and `pop_data_o` is 0x00.
- R6: The pointer wraps modulo 256. A push from 0xFF writes address 0x00 and leaves 0x00. A pop from 0x00 leaves 0xFF.
- R7: When `push_i` and `pop_i` are both high, the push is performed and the pop has no effect: there is no pointer decrement and no valid flag in the next cycle.
- R8: When `sp_load_i` is high, `sp_o` becomes `sp_load_val_i` after the edge, whatever the state of `push_i` and `pop_i`. In that cycle there is no RAM write, and a push or pop in the same cycle is dropped.
- R9: With no strobe high, `sp_o` holds its value and `ram_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe, one cycle per byte |
| pop_i | input | 1 | Pop strobe, one cycle per byte |
| push_data_i | input | 8 | Byte to store on a push |
| sp_load_i | input | 1 | Software load strobe for the pointer |
| sp_load_val_i | input | 8 | New pointer value for a load |
| sp_o | output | 8 | Current stack pointer |
| pop_valid_o | output | 1 | Popped byte is present on `pop_data_o` |
| pop_data_o | output | 8 | Popped byte, 0x00 when not valid |
| ram_addr_o | output | 8 | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, registered one cycle after the address |

## Verification
The assertions assume that the RAM behind the port returns, one cycle later, the byte at the address presented. They also assume that the strobes are clean single-cycle levels sampled at the rising edge, and that each pop targets a location the same run has written or that the bench model has cleared to 0x00. The bench model clears its RAM under reset and answers reads with one cycle of latency, so every popped byte has a known value. The bench drives strobes only at the falling edge. The conflicting combinations (push with pop, load with push, load with pop) are driven on purpose, because the priority rules define the outcome for each of them.

// File: rtl/upstack_pkg.sv
package upstack_pkg;

    // Default geometry of the stack and its RAM.
    localparam int          PTR_W_DEF   = 8;
    localparam int          DATA_W_DEF  = 8;
    localparam logic [7:0]  PTR_RST_DEF = 8'h07;

    // One operation is granted per cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_LOAD = 2'd3
    } stk_op_e;

    // One-hot grant lines from the arbiter.
    typedef struct packed {
        logic load_go;
        logic push_go;
        logic pop_go;
    } stk_grant_t;

    // Priority: load over push over pop.
    function automatic stk_grant_t resolve_grant(input logic load_r,
                                                 input logic push_r,
                                                 input logic pop_r);
        stk_grant_t g;
        g.load_go = load_r;
        g.push_go = push_r & ~load_r;
        g.pop_go  = pop_r & ~push_r & ~load_r;
        return g;
    endfunction

    function automatic stk_op_e grant_to_op(input stk_grant_t g);
        stk_op_e op;
        if (g.load_go)      op = OP_LOAD;
        else if (g.push_go) op = OP_PUSH;
        else if (g.pop_go)  op = OP_POP;
        else                op = OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/upstack_arbiter.sv
module upstack_arbiter
    import upstack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       push_i,
    input  logic       pop_i,
    input  logic       load_i,
    output stk_grant_t grant_o,
    output stk_op_e    op_o
);

    stk_grant_t grant_c;

    always_comb begin
        grant_c = resolve_grant(load_i, push_i, pop_i);
    end

    assign grant_o = grant_c;
    assign op_o    = grant_to_op(grant_c);

    // R7 / R8: never more than one operation granted
    a_r7_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant_o.load_go, grant_o.push_go, grant_o.pop_go}));

    // R7: a push request with pop and no load becomes a push
    a_r7_push_wins: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && !load_i) |-> (op_o == OP_PUSH));

    // R8: a load request always wins
    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (op_o == OP_LOAD));

endmodule

// File: rtl/upstack_ptr.sv
module upstack_ptr
    import upstack_pkg::*;
#(
    parameter int               PTR_W   = PTR_W_DEF,
    parameter logic [PTR_W-1:0] PTR_RST = PTR_RST_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op_i,
    input  logic [PTR_W-1:0] load_val_i,
    output logic [PTR_W-1:0] sp_o,
    output logic [PTR_W-1:0] sp_up_o
);

    localparam logic [PTR_W-1:0] ONE     = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_TOP = {PTR_W{1'b1}};

    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_up;
    logic [PTR_W-1:0] sp_dn;
    logic [PTR_W-1:0] sp_d;

    // Modulo 2**PTR_W arithmetic; the carry is dropped on purpose.
    assign sp_up = sp_q + ONE;
    assign sp_dn = sp_q - ONE;

    always_comb begin
        unique case (op_i)
            OP_PUSH: sp_d = sp_up;
            OP_POP:  sp_d = sp_dn;
            OP_LOAD: sp_d = load_val_i;
            default: sp_d = sp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= PTR_RST;
        else     sp_q <= sp_d;
    end

    assign sp_o    = sp_q;
    assign sp_up_o = sp_up;

    a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sp_q == PTR_RST));

    a_r2_push_moves_up: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_PUSH) |=> (sp_q == $past(sp_q) + ONE));

    a_r4_pop_moves_down: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_POP) |=> (sp_q == $past(sp_q) - ONE));

    a_r6_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_PUSH && sp_q == PTR_TOP) |=> (sp_q == '0));

    a_r6_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_POP && sp_q == '0) |=> (sp_q == PTR_TOP));

    a_r8_load_taken: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_LOAD) |=> (sp_q == $past(load_val_i)));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_IDLE) |=> $stable(sp_q));

endmodule

// File: rtl/upstack_ramseq.sv
module upstack_ramseq
    import upstack_pkg::*;
#(
    parameter int PTR_W  = PTR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_op_e           op_i,
    input  logic [PTR_W-1:0]  sp_i,
    input  logic [PTR_W-1:0]  sp_up_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic [PTR_W-1:0]  ram_addr_o,
    output logic              ram_we_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic              pop_valid_o,
    output logic [DATA_W-1:0] pop_data_o
);

    logic rd_pending_q;

    // Push writes at the pre-incremented pointer; every other cycle
    // addresses the current pointer, which is the pop read location.
    always_comb begin
        ram_we_o    = 1'b0;
        ram_addr_o  = sp_i;
        ram_wdata_o = '0;
        if (op_i == OP_PUSH) begin
            ram_we_o    = 1'b1;
            ram_addr_o  = sp_up_i;
            ram_wdata_o = push_data_i;
        end
    end

    // The RAM answers one cycle after the address; track that cycle.
    always_ff @(posedge clk) begin
        if (rst) rd_pending_q <= 1'b0;
        else     rd_pending_q <= (op_i == OP_POP);
    end

    assign pop_valid_o = rd_pending_q;
    assign pop_data_o  = rd_pending_q ? ram_rdata_i : '0;

    a_r4_pop_reads_sp: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_POP) |-> (!ram_we_o && ram_addr_o == sp_i));

    a_r5_valid_after_pop: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_POP) |=> pop_valid_o);

    a_r5_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_POP) |=> !pop_valid_o);

    a_r5_data_quiet: assert property (@(posedge clk) disable iff (rst)
        !pop_valid_o |-> (pop_data_o == '0));

endmodule

// File: rtl/upstack_unit.sv
module upstack_unit
    import upstack_pkg::*;
#(
    parameter int               PTR_W   = PTR_W_DEF,
    parameter int               DATA_W  = DATA_W_DEF,
    parameter logic [PTR_W-1:0] PTR_RST = PTR_RST_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              sp_load_i,
    input  logic [PTR_W-1:0]  sp_load_val_i,
    output logic [PTR_W-1:0]  sp_o,
    output logic              pop_valid_o,
    output logic [DATA_W-1:0] pop_data_o,
    output logic [PTR_W-1:0]  ram_addr_o,
    output logic              ram_we_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    input  logic [DATA_W-1:0] ram_rdata_i
);

    stk_grant_t       grant;
    stk_op_e          op;
    logic [PTR_W-1:0] sp_cur;
    logic [PTR_W-1:0] sp_up;

    upstack_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .load_i  (sp_load_i),
        .grant_o (grant),
        .op_o    (op)
    );

    upstack_ptr #(
        .PTR_W   (PTR_W),
        .PTR_RST (PTR_RST)
    ) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op),
        .load_val_i (sp_load_val_i),
        .sp_o       (sp_cur),
        .sp_up_o    (sp_up)
    );

    upstack_ramseq #(
        .PTR_W  (PTR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op),
        .sp_i        (sp_cur),
        .sp_up_i     (sp_up),
        .push_data_i (push_data_i),
        .ram_rdata_i (ram_rdata_i),
        .ram_addr_o  (ram_addr_o),
        .ram_we_o    (ram_we_o),
        .ram_wdata_o (ram_wdata_o),
        .pop_valid_o (pop_valid_o),
        .pop_data_o  (pop_data_o)
    );

    assign sp_o = sp_cur;

    // Port-level checks across the three sub-blocks.
    a_r2_write_above_sp: assert property (@(posedge clk) disable iff (rst)
        ram_we_o |-> (ram_addr_o == sp_o + PTR_W'(1) && ram_wdata_o == push_data_i));

    a_r7_push_over_pop: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && !sp_load_i) |-> ram_we_o);

    a_r8_no_write_on_load: assert property (@(posedge clk) disable iff (rst)
        sp_load_i |-> !ram_we_o);

    a_r9_write_needs_push: assert property (@(posedge clk) disable iff (rst)
        !push_i |-> !ram_we_o);

    a_r5_one_cycle_valid: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !sp_load_i) |=> pop_valid_o);

endmodule

// File: tb/sim_upstack_unit.sv
`timescale 1ns/1ps
module sim_upstack_unit;

    typedef struct packed {
        logic       push;
        logic       pop;
        logic       ld;
        logic [7:0] din;
        logic [7:0] exp_sp;
        logic       exp_v;
        logic [7:0] exp_dat;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 17;
    // din feeds both push data and load value.
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 8'hA1, 8'h08, 1'b0, 8'h00, 4'd3}, // R3 first push at 08
        '{1'b1, 1'b0, 1'b0, 8'hB2, 8'h09, 1'b0, 8'h00, 4'd2}, // R2
        '{1'b1, 1'b0, 1'b0, 8'hC3, 8'h0A, 1'b0, 8'h00, 4'd2}, // R2
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h09, 1'b1, 8'hC3, 4'd4}, // R4
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h08, 1'b1, 8'hB2, 4'd5}, // R5
        '{1'b1, 1'b1, 1'b0, 8'hD4, 8'h09, 1'b0, 8'h00, 4'd7}, // R7 push wins
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h08, 1'b1, 8'hD4, 4'd7}, // R7 data was pushed
        '{1'b1, 1'b0, 1'b1, 8'hFE, 8'hFE, 1'b0, 8'h00, 4'd8}, // R8 load over push
        '{1'b1, 1'b0, 1'b0, 8'h66, 8'hFF, 1'b0, 8'h00, 4'd2}, // R2
        '{1'b1, 1'b0, 1'b0, 8'h77, 8'h00, 1'b0, 8'h00, 4'd6}, // R6 wrap up
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h77, 4'd6}, // R6 read at 00
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'hFE, 1'b1, 8'h66, 4'd4}, // R4
        '{1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 8'h00, 4'd8}, // R8 load over pop
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h77, 4'd6}, // R6 wrap down
        '{1'b0, 1'b0, 1'b1, 8'hFE, 8'hFE, 1'b0, 8'h00, 4'd8}, // R8 plain load
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'hFD, 1'b1, 8'h00, 4'd8}, // R8 dropped push left FE clear
        '{1'b0, 1'b0, 1'b0, 8'h00, 8'hFD, 1'b0, 8'h00, 4'd9}  // R9 idle
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push_i = 1'b0;
    logic       pop_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       sp_load_i = 1'b0;
    logic [7:0] sp_load_val_i = '0;
    logic [7:0] sp_o;
    logic       pop_valid_o;
    logic [7:0] pop_data_o;
    logic [7:0] ram_addr_o;
    logic       ram_we_o;
    logic [7:0] ram_wdata_o;
    logic [7:0] ram_rdata_i;

    logic [7:0] mem [256];

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    upstack_unit u0 (
        .clk           (clk),
        .rst           (rst),
        .push_i        (push_i),
        .pop_i         (pop_i),
        .push_data_i   (push_data_i),
        .sp_load_i     (sp_load_i),
        .sp_load_val_i (sp_load_val_i),
        .sp_o          (sp_o),
        .pop_valid_o   (pop_valid_o),
        .pop_data_o    (pop_data_o),
        .ram_addr_o    (ram_addr_o),
        .ram_we_o      (ram_we_o),
        .ram_wdata_o   (ram_wdata_o),
        .ram_rdata_i   (ram_rdata_i)
    );

    // RAM model: synchronous write, one-cycle registered read, cleared under reset.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
            ram_rdata_i <= 8'h00;
        end else begin
            if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
            ram_rdata_i <= mem[ram_addr_o];
        end
    end

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic p, input logic q, input logic l, input logic [7:0] d);
        push_i        = p;
        pop_i         = q;
        sp_load_i     = l;
        push_data_i   = d;
        sp_load_val_i = d;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "sp after reset", sp_o, 8'h07);
        check("R1", "valid after reset", {7'b0, pop_valid_o}, 8'h00);
        rst = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k].push, VEC[k].pop, VEC[k].ld, VEC[k].din);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d", VEC[k].req), "sp", sp_o, VEC[k].exp_sp);
            check($sformatf("R%0d", VEC[k].req), "pop_valid",
                  {7'b0, pop_valid_o}, {7'b0, VEC[k].exp_v});
            if (VEC[k].exp_v)
                check($sformatf("R%0d", VEC[k].req), "pop_data", pop_data_o, VEC[k].exp_dat);
            else
                check("R5", "pop_data quiet", pop_data_o, 8'h00);
        end

        // R9: idle drives no write
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        #1;
        check("R9", "idle we", {7'b0, ram_we_o}, 8'h00);

        // R2: RAM port during a push, sp = FD
        drive(1'b1, 1'b0, 1'b0, 8'h5A);
        #1;
        check("R2", "push addr", ram_addr_o, 8'hFE);
        check("R2", "push we", {7'b0, ram_we_o}, 8'h01);
        check("R2", "push wdata", ram_wdata_o, 8'h5A);

        // R8: load with push writes nothing
        drive(1'b1, 1'b0, 1'b1, 8'h40);
        #1;
        check("R8", "load we", {7'b0, ram_we_o}, 8'h00);

        // R1: reset in mid-run
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 8'h00);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "sp after mid reset", sp_o, 8'h07);
        check("R1", "valid after mid reset", {7'b0, pop_valid_o}, 8'h00);
        rst = 1'b0;

        // R3: first push after that reset targets 08
        drive(1'b1, 1'b0, 1'b0, 8'h11);
        #1;
        check("R3", "first push addr", ram_addr_o, 8'h08);
        @(posedge clk);
        @(negedge clk);
        check("R3", "sp after first push", sp_o, 8'h08);
        drive(1'b0, 1'b0, 1'b0, 8'h00);

        done = 1'b1;
        report();
    end

endmodule